// File: doc/BRIEF.md
# I2C Bus Observer with Address Classification

This block watches the two lines of an I2C bus without ever driving them. Both lines pass through a synchroniser and a small majority-free stability filter. The filtered levels are used to recognise bus conditions: a START (data falling while clock is high), a repeated START (the same event while the bus is already owned), and a STOP (data rising while clock is high). A bus-busy flag is held from START until STOP.

Inside each transaction the block collects the addressing byte or bytes and reports one classification per address phase. A plain 7-bit address is reported at once. Several codes are reported as special classes: the all-zero code with a write bit, the all-zero code with a read bit, the reserved low codes, and the five-bit prefix that starts a 10-bit address. For the general call and for the 10-bit prefix, the report waits for the second byte. Each report carries a class code, a 10-bit address field, the direction bit and the acknowledge seen on the bus, and it comes with a one-cycle valid strobe. A STOP at any point abandons whatever was being collected.

The block is meant for debug taps, bus ownership tracking, and arbitration-aware logic that must know who is being addressed.

Top module: `i2c_bus_observer`

## Requirements
- R1: While reset is held and right after it, the event pulses and `addr_valid` are low, `bus_busy` is low and the classification outputs are zero.
- R2: A filtered data fall while the clock is high gives a one-cycle `start_pulse` when the bus is idle, and it sets `bus_busy`. A filtered data rise while the clock is high gives a one-cycle `stop_pulse` and clears `bus_busy`.
- R3: A START seen while `bus_busy` is high gives `rstart_pulse` instead of `start_pulse`, and `bus_busy` stays high.
- R4: A level on either line that lasts for fewer than two consecutive synchronised samples has no effect; a one-cycle data dip while the clock is high produces no START.
- R5: A first byte that is not a special code is reported with `addr_class` 0, `addr_value` = byte bits 7..1 zero-extended, and `addr_rw` = byte bit 0. The report comes after the ninth (acknowledge) clock of that byte.
- R6: `addr_ack` is 1 when data was low on the acknowledge clock of the byte that completed the report, and 0 when it was high.
- R7: First byte 0x01 gives class 3 (start byte). 0x02 and 0x03 give class 4 (legacy three-wire bus). 0x04 and 0x05 give class 5 (other bus format). 0x06 through 0x0F give class 6 (reserved). For all of these `addr_value` = bits 7..1.
- R8: A first byte 0x00 gives no report of its own. If the second byte has bit 0 clear, class 1 is reported with `addr_value` = that byte zero-extended. If bit 0 is set, class 2 (sender announcement) is reported with `addr_value` = its bits 7..1. In both cases `addr_rw` = 0.
- R9: A first byte 11110 a9 a8 d gives no report of its own. The next byte b completes class 7 with `addr_value` = {a9, a8, b}, `addr_rw` = d, and the acknowledge of the second byte.
- R10: A STOP in the middle of any byte ends collection with no report. The following START collects a fresh first byte from bit 7.
- R11: After an address phase has been reported, later bytes of the same transaction produce no report. A repeated START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Observed bus clock line |
| sda_i | input | 1 | Observed bus data line |
| start_pulse | output | 1 | One-cycle pulse on START from idle |
| rstart_pulse | output | 1 | One-cycle pulse on START while busy |
| stop_pulse | output | 1 | One-cycle pulse on STOP |
| bus_busy | output | 1 | High from START until STOP |
| addr_valid | output | 1 | One-cycle strobe for a new classification |
| addr_class | output | 3 | Class code (0 normal, 1 general call, 2 sender announcement, 3 start byte, 4 legacy bus, 5 other format, 6 reserved, 7 ten-bit) |
| addr_value | output | 10 | Address field for the reported class |
| addr_rw | output | 1 | Direction bit, 1 = read |
| addr_ack | output | 1 | 1 when the closing byte was acknowledged |

## Verification
A wrong bit counter shows up on the next reported address as a shifted `addr_value` or a wrong class, so it is visible at the end of the first address phase. A classifier stuck in a waiting state either drops the report, which appears as a missing `addr_valid` after the second byte, or reports on a data byte, which appears as an extra strobe in the same transaction. A busy flag that does not clear turns the next START into a repeated-START pulse, and that shows on the very next transaction. A filter that is too weak turns a one-cycle glitch into a spurious START within a few cycles.

// File: rtl/i2c_obs_pkg.sv
package i2c_obs_pkg;

   localparam int BYTE_W  = 8;
   localparam int ADDR_W  = 10;
   localparam int CLASS_W = 3;

   typedef enum logic [CLASS_W-1:0] {
      CLS_NORM7   = 3'd0,
      CLS_GCALL   = 3'd1,
      CLS_GCHOST  = 3'd2,
      CLS_STBYTE  = 3'd3,
      CLS_LEGACY  = 3'd4,
      CLS_ALTFMT  = 3'd5,
      CLS_RSVD    = 3'd6,
      CLS_TENBIT  = 3'd7
   } cls_e;

   // Classify a first address byte. General call and ten-bit prefix need a
   // second byte; the caller handles that deferral.
   function automatic cls_e first_class(input logic [BYTE_W-1:0] b);
      cls_e c;
      if (b[7:1] == 7'b0000000)
         c = b[0] ? CLS_STBYTE : CLS_GCALL;
      else if (b[7:1] == 7'b0000001)
         c = CLS_LEGACY;
      else if (b[7:1] == 7'b0000010)
         c = CLS_ALTFMT;
      else if (b[7:4] == 4'b0000)
         c = CLS_RSVD;
      else if (b[7:3] == 5'b11110)
         c = CLS_TENBIT;
      else
         c = CLS_NORM7;
      return c;
   endfunction

endpackage

// File: rtl/i2c_obs_filter.sv
module i2c_obs_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);

   if (SYNC_STAGES < 2) begin : g_sync_chk
      $error("i2c_obs_filter: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 2) begin : g_filt_chk
      $error("i2c_obs_filter: FILT_LEN must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [FILT_LEN-1:0]    hist_q;
   logic                   samp_w;

   // bus idles high, so every stage resets to one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end

   assign samp_w = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '1;
         line_o <= 1'b1;
      end else begin
         hist_q <= {hist_q[FILT_LEN-2:0], samp_w};
         if (&hist_q)
            line_o <= 1'b1;
         else if (~|hist_q)
            line_o <= 1'b0;
      end
   end

   // R4
   filt_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(line_o) |-> ($past(samp_w, 2) == line_o) && ($past(samp_w, 3) == line_o));

endmodule

// File: rtl/i2c_obs_cond.sv
module i2c_obs_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic start_o,
   output logic rstart_o,
   output logic stop_o,
   output logic busy_o
);

   logic scl_prev_q, sda_prev_q;
   logic start_w, stop_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev_q <= 1'b1;
         sda_prev_q <= 1'b1;
      end else begin
         scl_prev_q <= scl_f;
         sda_prev_q <= sda_f;
      end
   end

   // data edge during a held-high clock
   assign start_w = scl_f & scl_prev_q &  sda_prev_q & ~sda_f;
   assign stop_w  = scl_f & scl_prev_q & ~sda_prev_q &  sda_f;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_o  <= 1'b0;
         rstart_o <= 1'b0;
         stop_o   <= 1'b0;
         busy_o   <= 1'b0;
      end else begin
         start_o  <= start_w & ~busy_o;
         rstart_o <= start_w &  busy_o;
         stop_o   <= stop_w;
         if (stop_w)
            busy_o <= 1'b0;
         else if (start_w)
            busy_o <= 1'b1;
      end
   end

   // R2
   start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> busy_o);

   // R2
   stop_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |-> !busy_o);

   // R3
   rstart_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rstart_o |=> busy_o || stop_o);

endmodule

// File: rtl/i2c_obs_shift.sv
module i2c_obs_shift
   import i2c_obs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_f,
   input  logic              sda_f,
   input  logic              clear_i,
   output logic              byte_stb_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic              ack_o
);

   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

   logic              scl_prev_q;
   logic              scl_rise_w;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_prev_q <= 1'b1;
      else        scl_prev_q <= scl_f;
   end

   assign scl_rise_w = scl_f & ~scl_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         sh_q       <= '0;
         byte_o     <= '0;
         ack_o      <= 1'b0;
         byte_stb_o <= 1'b0;
      end else begin
         byte_stb_o <= 1'b0;
         if (clear_i) begin
            cnt_q <= '0;
         end else if (scl_rise_w) begin
            if (cnt_q == ACK_SLOT) begin
               byte_o     <= sh_q;
               ack_o      <= ~sda_f;
               byte_stb_o <= 1'b1;
               cnt_q      <= '0;
            end else begin
               sh_q  <= {sh_q[BYTE_W-2:0], sda_f};
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R10
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= ACK_SLOT);

   // R5
   stb_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_stb_o |-> $past(scl_f) && !$past(scl_prev_q));

endmodule

// File: rtl/i2c_obs_class.sv
module i2c_obs_class
   import i2c_obs_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               stop_i,
   input  logic               byte_stb_i,
   input  logic [BYTE_W-1:0]  byte_i,
   input  logic               ack_i,
   output logic               valid_o,
   output cls_e               cls_o,
   output logic [ADDR_W-1:0]  addr_o,
   output logic               rw_o,
   output logic               ack_o
);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FIRST,
      ST_TEN,
      ST_GC,
      ST_DONE
   } st_e;

   st_e        st_q;
   logic [1:0] hi_q;
   logic       dir_q;
   cls_e       fc_w;

   assign fc_w = first_class(byte_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         hi_q    <= '0;
         dir_q   <= 1'b0;
         valid_o <= 1'b0;
         cls_o   <= CLS_NORM7;
         addr_o  <= '0;
         rw_o    <= 1'b0;
         ack_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (stop_i) begin
            st_q <= ST_IDLE;
         end else if (start_i) begin
            st_q <= ST_FIRST;
         end else if (byte_stb_i) begin
            case (st_q)
               ST_FIRST: begin
                  if (fc_w == CLS_TENBIT) begin
                     hi_q  <= byte_i[2:1];
                     dir_q <= byte_i[0];
                     st_q  <= ST_TEN;
                  end else if (fc_w == CLS_GCALL) begin
                     st_q <= ST_GC;
                  end else begin
                     valid_o <= 1'b1;
                     cls_o   <= fc_w;
                     addr_o  <= {3'b000, byte_i[7:1]};
                     rw_o    <= byte_i[0];
                     ack_o   <= ack_i;
                     st_q    <= ST_DONE;
                  end
               end
               ST_TEN: begin
                  valid_o <= 1'b1;
                  cls_o   <= CLS_TENBIT;
                  addr_o  <= {hi_q, byte_i};
                  rw_o    <= dir_q;
                  ack_o   <= ack_i;
                  st_q    <= ST_DONE;
               end
               ST_GC: begin
                  valid_o <= 1'b1;
                  rw_o    <= 1'b0;
                  ack_o   <= ack_i;
                  if (byte_i[0]) begin
                     cls_o  <= CLS_GCHOST;
                     addr_o <= {3'b000, byte_i[7:1]};
                  end else begin
                     cls_o  <= CLS_GCALL;
                     addr_o <= {2'b00, byte_i};
                  end
                  st_q <= ST_DONE;
               end
               default: st_q <= st_q;
            endcase
         end
      end
   end

   // R11
   single_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R8
   gc_write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && (cls_o == CLS_GCALL || cls_o == CLS_GCHOST) |-> !rw_o);

   // R11
   report_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> st_q == ST_DONE);

endmodule

// File: rtl/i2c_bus_observer.sv
module i2c_bus_observer
   import i2c_obs_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              start_pulse,
   output logic              rstart_pulse,
   output logic              stop_pulse,
   output logic              bus_busy,
   output logic              addr_valid,
   output logic [CLASS_W-1:0] addr_class,
   output logic [ADDR_W-1:0] addr_value,
   output logic              addr_rw,
   output logic              addr_ack
);

   localparam int N_LINES = 2;

   logic [N_LINES-1:0] raw_w;
   logic [N_LINES-1:0] filt_w;
   logic               scl_f, sda_f;
   logic               clr_w;
   logic               stb_w;
   logic [BYTE_W-1:0]  byte_w;
   logic               back_w;
   cls_e               cls_w;

   assign raw_w = {sda_i, scl_i};

   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      i2c_obs_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .FILT_LEN    (FILT_LEN)
      ) filt_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (raw_w[g]),
         .line_o (filt_w[g])
      );
   end

   assign scl_f = filt_w[0];
   assign sda_f = filt_w[1];

   i2c_obs_cond cond_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_f    (scl_f),
      .sda_f    (sda_f),
      .start_o  (start_pulse),
      .rstart_o (rstart_pulse),
      .stop_o   (stop_pulse),
      .busy_o   (bus_busy)
   );

   assign clr_w = start_pulse | rstart_pulse | stop_pulse;

   i2c_obs_shift shift_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_f      (scl_f),
      .sda_f      (sda_f),
      .clear_i    (clr_w),
      .byte_stb_o (stb_w),
      .byte_o     (byte_w),
      .ack_o      (back_w)
   );

   i2c_obs_class class_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_pulse | rstart_pulse),
      .stop_i     (stop_pulse),
      .byte_stb_i (stb_w),
      .byte_i     (byte_w),
      .ack_i      (back_w),
      .valid_o    (addr_valid),
      .cls_o      (cls_w),
      .addr_o     (addr_value),
      .rw_o       (addr_rw),
      .ack_o      (addr_ack)
   );

   assign addr_class = cls_w;

   // R10
   report_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |-> bus_busy);

   // R2
   one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_pulse, rstart_pulse, stop_pulse}));

endmodule

// File: tb/i2c_bus_observer_tb_top.sv
`timescale 1ns/1ps
module i2c_bus_observer_tb_top;

   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda = 1'b1;
   logic       start_pulse, rstart_pulse, stop_pulse, bus_busy;
   logic       addr_valid, addr_rw, addr_ack;
   logic [2:0] addr_class;
   logic [9:0] addr_value;

   int n_run = 0, n_fail = 0;
   int n_st = 0, n_rs = 0, n_sp = 0, n_val = 0;
   int l_cls = 0, l_addr = 0, l_rw = 0, l_ack = 0;
   bit done = 0;

   always #10 clk = ~clk;

   i2c_bus_observer dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl),
      .sda_i        (sda),
      .start_pulse  (start_pulse),
      .rstart_pulse (rstart_pulse),
      .stop_pulse   (stop_pulse),
      .bus_busy     (bus_busy),
      .addr_valid   (addr_valid),
      .addr_class   (addr_class),
      .addr_value   (addr_value),
      .addr_rw      (addr_rw),
      .addr_ack     (addr_ack)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (start_pulse)  n_st++;
         if (rstart_pulse) n_rs++;
         if (stop_pulse)   n_sp++;
         if (addr_valid) begin
            n_val++;
            l_cls  = addr_class;
            l_addr = addr_value;
            l_rw   = addr_rw;
            l_ack  = addr_ack;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n * Q) @(posedge clk);
   endtask

   task automatic bus_start();
      sda = 1'b0; wq(2); scl = 1'b0; wq(1);
   endtask

   task automatic bus_rstart();
      sda = 1'b1; wq(1); scl = 1'b1; wq(1); sda = 1'b0; wq(1); scl = 1'b0; wq(1);
   endtask

   task automatic bus_stop();
      sda = 1'b0; wq(1); scl = 1'b1; wq(1); sda = 1'b1; wq(3);
   endtask

   task automatic bus_bit(input logic b);
      sda = b; wq(1); scl = 1'b1; wq(2); scl = 1'b0; wq(1);
   endtask

   task automatic bus_byte(input logic [7:0] b, input logic ack);
      for (int i = 7; i >= 0; i--) bus_bit(b[i]);
      bus_bit(~ack);
   endtask

   task automatic chk_report(input string tag, input int v0, input int cls,
                             input int addr, input int rw, input int ack);
      chk({tag, " count"}, n_val, v0 + 1);
      chk({tag, " class"}, l_cls, cls);
      chk({tag, " addr"},  l_addr, addr);
      chk({tag, " rw"},    l_rw, rw);
      chk({tag, " ack"},   l_ack, ack);
   endtask

   task automatic t_reset();
      chk("R1 busy", int'(bus_busy), 0);
      chk("R1 valid", int'(addr_valid), 0);
      chk("R1 pulses", int'({start_pulse, rstart_pulse, stop_pulse}), 0);
      chk("R1 class", int'(addr_class), 0);
      chk("R1 addr", int'(addr_value), 0);
   endtask

   task automatic t_norm7();
      int v0 = n_val, s0 = n_st, p0 = n_sp;
      bus_start();
      chk("R2 start pulse", n_st, s0 + 1);
      chk("R2 busy set", int'(bus_busy), 1);
      bus_byte(8'hA0, 1'b1);
      chk_report("R5 write", v0, 0, 8'h50, 0, 1);
      bus_byte(8'h00, 1'b1);
      bus_byte(8'hF0, 1'b0);
      chk("R11 no report on data", n_val, v0 + 1);
      bus_stop();
      chk("R2 stop pulse", n_sp, p0 + 1);
      chk("R2 busy clear", int'(bus_busy), 0);
   endtask

   task automatic t_read_nack();
      int v0 = n_val;
      bus_start(); bus_byte(8'h77, 1'b0);
      chk_report("R6 nack read", v0, 0, 8'h3B, 1, 0);
      bus_stop();
   endtask

   task automatic t_reserved(input logic [7:0] b, input int cls);
      int v0 = n_val;
      bus_start(); bus_byte(b, 1'b0);
      chk_report("R7 reserved", v0, cls, int'(b[7:1]), int'(b[0]), 0);
      bus_stop();
   endtask

   task automatic t_gcall(input logic [7:0] b2, input int cls, input int addr);
      int v0 = n_val;
      bus_start(); bus_byte(8'h00, 1'b1);
      chk("R8 deferred", n_val, v0);
      bus_byte(b2, 1'b1);
      chk_report("R8 general call", v0, cls, addr, 0, 1);
      bus_byte(8'h5A, 1'b1);
      chk("R11 gc data ignored", n_val, v0 + 1);
      bus_stop();
   endtask

   task automatic t_tenbit();
      int v0 = n_val;
      bus_start(); bus_byte(8'hF5, 1'b1);
      chk("R9 deferred", n_val, v0);
      bus_byte(8'h3C, 1'b0);
      chk_report("R9 ten-bit", v0, 7, 10'h23C, 1, 0);
      bus_stop();
   endtask

   task automatic t_stbyte_rstart();
      int v0 = n_val, s0 = n_st, r0 = n_rs;
      bus_start(); bus_byte(8'h01, 1'b0);
      chk_report("R7 start byte", v0, 3, 0, 1, 0);
      bus_rstart();
      chk("R3 rstart pulse", n_rs, r0 + 1);
      chk("R3 no start pulse", n_st, s0 + 1);
      chk("R3 busy kept", int'(bus_busy), 1);
      bus_byte(8'h91, 1'b1);
      chk_report("R11 after rstart", v0 + 1, 0, 8'h48, 1, 1);
      bus_stop();
   endtask

   task automatic t_abort();
      int v0 = n_val, p0 = n_sp;
      bus_start();
      bus_bit(1'b0); bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
      bus_stop();
      chk("R10 abort no report", n_val, v0);
      chk("R10 abort stop", n_sp, p0 + 1);
      chk("R10 abort idle", int'(bus_busy), 0);
      bus_start(); bus_byte(8'h22, 1'b1);
      chk_report("R10 fresh byte", v0, 0, 8'h11, 0, 1);
      bus_stop();
   endtask

   task automatic t_glitch();
      int s0 = n_st;
      wq(2);
      @(posedge clk); sda = 1'b0;
      @(posedge clk); sda = 1'b1;
      wq(2);
      chk("R4 glitch no start", n_st, s0);
      chk("R4 glitch idle", int'(bus_busy), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      wq(2);
      t_reset();
      t_norm7();
      t_read_nack();
      t_reserved(8'h03, 4);
      t_reserved(8'h04, 5);
      t_reserved(8'h0E, 6);
      t_reserved(8'h07, 6);
      t_gcall(8'h06, 1, 6);
      t_gcall(8'hA5, 2, 8'h52);
      t_tenbit();
      t_stbyte_rstart();
      t_abort();
      t_glitch();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule